// File: doc/BRIEF.md
# GPIO Edge and Level Event Detector

This block watches 54 general-purpose input pins, arranged as two 32-bit banks (the upper ten lanes of the second bank are unimplemented). For every pin, software can arm any mix of six trigger conditions:
- a synchronous rising edge;
- a synchronous falling edge;
- a high level;
- a low level;
- a fast rising edge, seen directly on the raw pin;
- a fast falling edge, seen directly on the raw pin.

When any armed condition holds for a pin, that pin's sticky event flag is set. The flag stays set until software writes a 1 to its bit.

Each bank drives its own interrupt line, which is high while any event flag in that bank is set. Software sets up and services the block through a simple word-addressed write/read bus. Reads are combinational and show the live contents of the addressed register.

Both-edge detection needs no separate mode: software arms the rising and falling enables of the same pin together. A level trigger that is still armed, and whose level is still present, sets its flag again on the cycle a clear is written. The flag therefore cannot be cleared until the level goes away or the enable is removed.

Top module: `gpio_evt_detect`

## Requirements
- R1: After reset, every enable register and every status register reads 0, and both interrupt outputs are low.
- R2: Byte addresses select the registers as follows, with bank 0 at the base and bank 1 at base+4:

  | Register | Base |
  |---|---|
  | Status | 0x40 |
  | Rising enable | 0x4C |
  | Falling enable | 0x58 |
  | High enable | 0x64 |
  | Low enable | 0x70 |
  | Fast-rising enable | 0x7C |
  | Fast-falling enable | 0x88 |

  Every other address (for example 0x48) reads 0, and a write to it changes nothing.
- R3: A synchronous rising or falling edge on an enabled pin sets its status bit on the third rising clock edge after the pin changes. The pin passes through two synchroniser flops, and the result is then compared with the previous sample.
- R4: Writing to a status word clears exactly the bits written as 1. Bits written as 0 keep their value.
- R5: If a pin's set condition and a clear of its bit happen on the same clock edge, the bit ends up set.
- R6: With high-level (or low-level) detection enabled and the synchronised level present, the status bit sets, and it sets again on the same edge that a clear is written.
- R7: A fast rising or falling edge sets the status bit on the first rising clock edge after the pin changes.
- R8: Arming both the rising and falling enables of one pin detects edges in both directions.
- R9: Interrupt output b is the OR of bank b's status bits. It rises and falls together with them.
- R10: Bits 22 to 31 of every bank-1 register (pins 54 to 63) always read 0, and writes to them have no effect.
- R11: A condition whose enable bit is 0 never sets a status bit. Enables for different conditions act independently and may be combined.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| pinIn | input | 54 | Raw pin levels, pin n on bit n |
| busAddr | input | 8 | Byte address for read and write |
| busWrEn | input | 1 | Write strobe, sampled on the rising clock edge |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Combinational read data of the addressed word |
| irq | output | 2 | Per-bank interrupt, bit b for bank b |

## Verification
Internal state shows up at the ports in a few predictable ways:
- **Wrong enable bit.** It appears on the very next read of that word. It also appears as a status bit that sets, or fails to set, one cycle (fast path) or three cycles (synchronous path) after the pin moves.
- **Stuck or lost status bit.** The interrupt line of its bank shows it in the same cycle, and a readback of the status word shows it immediately.
- **Misaligned synchroniser stage.** Edge flags appear a cycle early or late, so edge timing is checked on exact cycles rather than within a window.

// File: rtl/gpio_evt_pkg.sv
package gpio_evt_pkg;
  localparam int NUM_PINS   = 54;
  localparam int BANK_W     = 32;
  localparam int NUM_BANKS  = (NUM_PINS + BANK_W - 1) / BANK_W;
  localparam int PAD_W      = NUM_BANKS * BANK_W;
  localparam int BANK_SEL_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;
  localparam int ADDR_W     = 8;
  localparam int EVT_BASE   = 'h40;
  localparam int GRP_STRIDE = 12;
  localparam int NUM_GRP    = 7;

  // Group order follows the address order: status first, then the six enables.
  typedef enum logic [2:0] {
    GRP_STAT  = 3'd0,
    GRP_RISE  = 3'd1,
    GRP_FALL  = 3'd2,
    GRP_HIGH  = 3'd3,
    GRP_LOW   = 3'd4,
    GRP_ARISE = 3'd5,
    GRP_AFALL = 3'd6,
    GRP_NONE  = 3'd7
  } evtGrp_e;

  typedef struct packed {
    logic                  wrEn;
    evtGrp_e               grp;
    logic [BANK_SEL_W-1:0] bank;
  } evtStrobe_t;
endpackage

// File: rtl/gpio_evt_ctrl.sv
module gpio_evt_ctrl
  import gpio_evt_pkg::*;
(
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  output evtStrobe_t        strobe
);
  evtGrp_e               hitGrp;
  logic [BANK_SEL_W-1:0] hitBank;

  // Compare the address against every (group, bank) word; anything else is unmapped.
  always_comb begin
    hitGrp  = GRP_NONE;
    hitBank = '0;
    for (int g = 0; g < NUM_GRP; g++) begin
      for (int b = 0; b < NUM_BANKS; b++) begin
        if (busAddr == ADDR_W'(EVT_BASE + g * GRP_STRIDE + b * 4)) begin
          hitGrp  = evtGrp_e'(3'(g));
          hitBank = BANK_SEL_W'(b);
        end
      end
    end
  end

  assign strobe.grp  = hitGrp;
  assign strobe.bank = hitBank;
  assign strobe.wrEn = busWrEn && (hitGrp != GRP_NONE);
endmodule

// File: rtl/gpio_evt_dp.sv
module gpio_evt_dp
  import gpio_evt_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_PINS-1:0]  pinIn,
  input  evtStrobe_t           strobe,
  input  logic [BANK_W-1:0]    busWrData,
  output logic [BANK_W-1:0]    busRdData,
  output logic [NUM_BANKS-1:0] irq
);
  localparam logic [PAD_W-1:0] VALID_MASK = {PAD_W{1'b1}} >> (PAD_W - NUM_PINS);

  logic [PAD_W-1:0] padIn;
  logic [PAD_W-1:0] syncA, syncB, prevQ, rawQ;
  logic [PAD_W-1:0] statQ;
  logic [PAD_W-1:0] enQ [NUM_GRP-1];
  logic [PAD_W-1:0] laneMask, laneData, clrVec, setCond, rdVec;
  logic [PAD_W-1:0] sRise, sFall, aRise, aFall;

  assign padIn    = PAD_W'(pinIn);
  assign laneMask = PAD_W'({BANK_W{1'b1}}) << (int'(strobe.bank) * BANK_W);
  assign laneData = (PAD_W'(busWrData) << (int'(strobe.bank) * BANK_W)) & VALID_MASK;
  assign clrVec   = (strobe.wrEn && strobe.grp == GRP_STAT) ? laneData : '0;

  // Synchronous path compares successive synchronised samples.
  // The fast path compares the raw pin with its last sample.
  assign sRise = syncB & ~prevQ;
  assign sFall = ~syncB & prevQ;
  assign aRise = padIn & ~rawQ & VALID_MASK;
  assign aFall = ~padIn & rawQ;

  assign setCond = (enQ[0] & sRise) | (enQ[1] & sFall) |
                   (enQ[2] & syncB) | (enQ[3] & ~syncB) |
                   (enQ[4] & aRise) | (enQ[5] & aFall);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA <= '0;
      syncB <= '0;
      prevQ <= '0;
      rawQ  <= '0;
      statQ <= '0;
      for (int g = 0; g < NUM_GRP - 1; g++) enQ[g] <= '0;
    end else begin
      syncA <= padIn & VALID_MASK;
      syncB <= syncA;
      prevQ <= syncB;
      rawQ  <= padIn & VALID_MASK;
      // A set on the same edge as a clear wins.
      statQ <= (setCond | (statQ & ~clrVec)) & VALID_MASK;
      for (int g = 0; g < NUM_GRP - 1; g++) begin
        if (strobe.wrEn && strobe.grp == evtGrp_e'(3'(g + 1)))
          enQ[g] <= (enQ[g] & ~laneMask) | laneData;
      end
    end
  end

  always_comb begin
    rdVec = '0;
    if (strobe.grp == GRP_STAT) rdVec = statQ;
    else if (strobe.grp != GRP_NONE) rdVec = enQ[3'(strobe.grp) - 3'd1];
  end
  assign busRdData = rdVec[int'(strobe.bank) * BANK_W +: BANK_W];

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_irq
    assign irq[b] = |statQ[b * BANK_W +: BANK_W];
  end

  // R4: cleared bits with no competing set end up 0.
  a_r4_clear: assert property (@(posedge clk) disable iff (!rstN)
    (|(clrVec & ~setCond)) |=> ((statQ & $past(clrVec & ~setCond)) == '0));

  // R4: bits not being cleared keep their value.
  a_r4_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (|(statQ & ~clrVec)) |=> ((statQ & $past(statQ & ~clrVec)) == $past(statQ & ~clrVec)));

  // R5: a set condition always lands in the status register.
  a_r5_set_wins: assert property (@(posedge clk) disable iff (!rstN)
    (|setCond) |=> ((statQ & $past(setCond)) == $past(setCond)));

  // R2: an enable word only changes when it is written.
  for (genvar g = 0; g < NUM_GRP - 1; g++) begin : g_enChk
    a_r2_en_hold: assert property (@(posedge clk) disable iff (!rstN)
      !(strobe.wrEn && strobe.grp == evtGrp_e'(3'(g + 1))) |=> $stable(enQ[g]));
  end
endmodule

// File: rtl/gpio_evt_detect.sv
module gpio_evt_detect
  import gpio_evt_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_PINS-1:0]  pinIn,
  input  logic [ADDR_W-1:0]    busAddr,
  input  logic                 busWrEn,
  input  logic [BANK_W-1:0]    busWrData,
  output logic [BANK_W-1:0]    busRdData,
  output logic [NUM_BANKS-1:0] irq
);
  evtStrobe_t strobe;

  gpio_evt_ctrl u_ctrl (
    .busAddr (busAddr),
    .busWrEn (busWrEn),
    .strobe  (strobe)
  );

  gpio_evt_dp u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .pinIn     (pinIn),
    .strobe    (strobe),
    .busWrData (busWrData),
    .busRdData (busRdData),
    .irq       (irq)
  );
endmodule

// File: tb/gpio_evt_detect_test.sv
module gpio_evt_detect_test;
  localparam int CLK_PERIOD = 20;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [53:0] pinIn = '0;
  logic [7:0]  busAddr = '0;
  logic        busWrEn = 1'b0;
  logic [31:0] busWrData = '0;
  logic [31:0] busRdData;
  logic [1:0]  irq;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  gpio_evt_detect uut (
    .clk(clk), .rstN(rstN), .pinIn(pinIn), .busAddr(busAddr),
    .busWrEn(busWrEn), .busWrData(busWrData), .busRdData(busRdData), .irq(irq)
  );

  // Reference model built from the requirements.
  localparam logic [63:0] VALID = {10'b0, {54{1'b1}}};
  logic [63:0] mS1, mS2, mPrev, mRaw, mStat;
  logic [63:0] mEn [6];

  always @(posedge clk or negedge rstN) begin
    logic [63:0] pad, setV, clrV, lane;
    if (!rstN) begin
      mS1 = '0; mS2 = '0; mPrev = '0; mRaw = '0; mStat = '0;
      for (int g = 0; g < 6; g++) mEn[g] = '0;
    end else begin
      pad  = {10'b0, pinIn};
      setV = (mEn[0] & mS2 & ~mPrev) | (mEn[1] & ~mS2 & mPrev) |
             (mEn[2] & mS2) | (mEn[3] & ~mS2) |
             (mEn[4] & pad & ~mRaw) | (mEn[5] & ~pad & mRaw);
      clrV = '0;
      if (busWrEn) begin
        for (int g = 0; g < 7; g++) begin
          for (int b = 0; b < 2; b++) begin
            if (busAddr == 8'(8'h40 + g * 12 + b * 4)) begin
              lane = (64'(busWrData) << (b * 32)) & VALID;
              if (g == 0) clrV = lane;
              else mEn[g-1] = (mEn[g-1] & ~(64'hFFFF_FFFF << (b * 32))) | lane;
            end
          end
        end
      end
      mStat = (setV | (mStat & ~clrV)) & VALID;
      mPrev = mS2; mS2 = mS1; mS1 = pad; mRaw = pad;
    end
  end

  function automatic logic [31:0] expBank(input int b);
    return mStat[b * 32 +: 32];
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic rdReg(input logic [7:0] a, output logic [31:0] d);
    busAddr = a;
    #1;
    d = busRdData;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chkStat(input string tag, input logic [31:0] e0, input logic [31:0] e1);
    logic [31:0] d;
    rdReg(8'h40, d); chk({tag, " bank0"}, d, e0);
    rdReg(8'h44, d); chk({tag, " bank1"}, d, e1);
    chk({tag, " irq"}, 32'(irq), 32'({|e1, |e0}));
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    int unsigned seed = 32'd20240611;
    void'($urandom(seed));
    idle(3);
    rstN = 1'b1;
    idle(1);

    // R1: reset state of every mapped word and both interrupts
    for (int g = 0; g < 7; g++) begin
      for (int b = 0; b < 2; b++) begin
        rdReg(8'(8'h40 + g * 12 + b * 4), d);
        chk("R1 reset word", d, 32'h0);
      end
    end
    chk("R1 reset irq", 32'(irq), 32'h0);

    // R2/R10: bank-1 upper lanes are unimplemented; reserved gap ignored
    wr(8'h50, 32'hFFFF_FFFF);
    rdReg(8'h50, d); chk("R10 bank1 rising enable", d, 32'h003F_FFFF);
    wr(8'h50, 32'h0);
    wr(8'h48, 32'hFFFF_FFFF);
    rdReg(8'h48, d); chk("R2 reserved reads zero", d, 32'h0);
    rdReg(8'h4C, d); chk("R2 reserved write no effect", d, 32'h0);

    // R3: synchronous rising edge on pin 3, exact cycle
    wr(8'h4C, 32'h0000_0008);
    pinIn[3] = 1'b1;
    idle(1); chkStat("R3 after 1 edge", 32'h0, 32'h0);
    idle(1); chkStat("R3 after 2 edges", 32'h0, 32'h0);
    idle(1); chkStat("R3 after 3 edges R9", 32'h8, 32'h0);

    // R4: writing 0 keeps, writing 1 clears
    wr(8'h40, 32'h0);        chkStat("R4 zero write", 32'h8, 32'h0);
    wr(8'h40, 32'h0000_0008); chkStat("R4 one clears", 32'h0, 32'h0);

    // R7: fast rising edge on pin 37 (bank1 bit 5)
    wr(8'h80, 32'h0000_0020);
    pinIn[37] = 1'b1;
    idle(1); chkStat("R7 fast rise R9", 32'h0, 32'h20);
    wr(8'h80, 32'h0);
    wr(8'h44, 32'h0000_0020); chkStat("R7 cleared", 32'h0, 32'h0);

    // R6/R5: high level on pin 0 re-sets on clear while present
    wr(8'h64, 32'h1);
    pinIn[0] = 1'b1;
    idle(3); chkStat("R6 high level set", 32'h1, 32'h0);
    wr(8'h40, 32'h1); chkStat("R5 set wins over clear", 32'h1, 32'h0);
    pinIn[0] = 1'b0;
    idle(4);
    wr(8'h40, 32'h1); chkStat("R6 clears once level gone", 32'h0, 32'h0);
    wr(8'h64, 32'h0);

    // R8: both edges on pin 7
    wr(8'h4C, 32'h0000_0088);
    wr(8'h58, 32'h0000_0080);
    pinIn[7] = 1'b1;
    idle(3); chkStat("R8 rising half", 32'h80, 32'h0);
    wr(8'h40, 32'h80);
    pinIn[7] = 1'b0;
    idle(2); chkStat("R8 not yet", 32'h0, 32'h0);
    idle(1); chkStat("R8 falling half", 32'h80, 32'h0);
    wr(8'h40, 32'h80);

    // R11: no enable on pin 10 means no event
    pinIn[10] = 1'b1;
    idle(5); chkStat("R11 disabled pin", 32'h0, 32'h0);

    // R6: low level on pin 12 (pin is low)
    wr(8'h70, 32'h0000_1000);
    idle(1); chkStat("R6 low level", 32'h1000, 32'h0);
    wr(8'h70, 32'h0);
    wr(8'h40, 32'h1000); chkStat("R6 low cleared", 32'h0, 32'h0);

    // Random phase, compared against the model each cycle (R3 R4 R5 R7 R9 R11)
    for (int i = 0; i < 600; i++) begin
      chkStat("R11 random", expBank(0), expBank(1));
      if ($urandom % 2 == 0) pinIn[$urandom % 54] ^= 1'b1;
      busWrEn = 1'b0;
      if ($urandom % 4 == 0) begin
        int k;
        k = int'($urandom % 16);
        busAddr   = (k < 14) ? 8'(8'h40 + (k / 2) * 12 + (k % 2) * 4) : ((k == 14) ? 8'h48 : 8'hA0);
        busWrData = ($urandom % 3 == 0) ? $urandom : ($urandom & $urandom & $urandom);
        busWrEn   = 1'b1;
      end
      @(negedge clk);
      busWrEn = 1'b0;
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule